// File: doc/BRIEF.md
# Six-Channel Down-Counting Interval Timer Bank

This block holds a set of independent 32-bit timers that count down. Software programs each channel through a word-addressed register port. Every channel has three registers:

- a control byte, which sets run, reload, tick source, divider and single-shot;
- an interval, which is the value loaded again on expiry;
- a current count, which can be overwritten at any moment.

The channel count comes from the `NUM_CH` parameter, which defaults to six.

Each channel counts the ticks of one of four tick-enable inputs, and a per-channel divider thins those ticks out. When a channel expires it raises its own pending flag. It then does one of three things:

- loads the interval again and keeps running;
- stops with its run bit cleared (single-shot);
- parks at zero (continuous mode without reload).

A shared enable mask decides which pending flags drive the single interrupt line. Software acknowledges an expiry by writing ones to the pending register.

Top module: `tmr_bank`

## Requirements
- R1: After synchronous reset every register reads 0 and `irq` is 0.
- R2: Offset 0x00 is the enable mask (bit n belongs to channel n). Offset 0x04 is the pending register. For channel n, offset 0x10+0x10·n holds control, 0x14+0x10·n the interval and 0x18+0x10·n the current count. Interval reads back as written. Control reads back bits 7:0 as written, and bits 31:8 read 0. Any other offset, including 0x08, 0x0C, 0x1C and channel slots at n ≥ NUM_CH, reads 0 and ignores writes.
- R3: Control bits 6:4 hold a divider value p. While the channel runs, it decrements once per p+1 ticks of its selected source. A control write restarts the division from zero.
- R4: Control bits 3:2 select which bit of `tick_src` counts for the channel. Ticks on the other bits have no effect.
- R5: While control bit 0 (run) is 0, the current count does not change unless software writes it.
- R6: With bit 7 = 0 and bit 1 (reload) = 1, the tick that would take the count from 1 to 0 loads the interval instead, sets the pending flag, and counting continues.
- R7: With bit 7 = 1 (single-shot), expiry takes the count to 0 and clears run; bit 1 has no effect. The count then stays at 0.
- R8: With bits 7 and 1 both 0, expiry takes the count to 0 and leaves run set. A count of 0 produces no further expiries.
- R9: An expiry sets the channel's pending bit whether or not its enable bit is set. Writing 1 to a pending bit clears it, writing 0 leaves it unchanged, and an expiry in the same cycle wins over the clear.
- R10: `irq` is 1 exactly when some channel has both its pending bit and its enable bit set.
- R11: A write to the current-count register sets the count on the next edge, even while the channel runs. In that cycle the write wins over a tick and suppresses expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_src | input | 4 | Tick-enable inputs, one per selectable source |
| irq | output | 1 | Interrupt request |

## Verification
The stimulus targets the following corner cases, each with the failure it would expose:

- **Expiry transition.** A timer that treats reaching zero as the start of an extra cycle, rather than as the 1→0 step, shows a period one tick too long.
- **Single-shot with reload set.** A timer that lets the reload bit override single-shot keeps firing.
- **Continuous mode without reload.** A timer that wraps to all-ones keeps firing.
- **Masked expiries.** These must still raise a pending bit. A design that gates pending by enable would lose expiries that software polls for.
- **Software writes in the same cycle as a tick.** A design that lets the tick win would lose the count software wrote.
- **Divider restart.** A control write must restart the divider. Otherwise the first period after reprogramming comes out short.
- **Unmapped offsets.** Writes there must leave every real register intact.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int CTRL_W  = 8;
    localparam int SRC_W   = 2;
    localparam int NUM_SRC = 1 << SRC_W;
    localparam int DIV_W   = 3;

    localparam logic [ADDR_W-1:0] OFS_EN  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PND = 8'h04;

    typedef enum logic [3:0] {
        SUB_CTRL = 4'h0,
        SUB_IVAL = 4'h4,
        SUB_CNT  = 4'h8
    } chan_sub_e;

    // Field order follows the control byte, bit 7 down to bit 0.
    typedef struct packed {
        logic             oneshot;
        logic [DIV_W-1:0] div;
        logic [SRC_W-1:0] src;
        logic             reload;
        logic             run;
    } tmr_ctrl_t;

    function automatic logic chan_hit(input logic [ADDR_W-1:0] a,
                                      input int unsigned ch,
                                      input chan_sub_e sub);
        return (a[7:4] == 4'(ch + 1)) && (a[3:0] == sub);
    endfunction

endpackage

// File: rtl/tmr_div.sv
module tmr_div
    import tmr_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic [DIV_W-1:0] limit,
    output logic             pulse
);
    logic [DIV_W-1:0] phase_q;

    assign pulse = tick && (phase_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= pulse ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_bank_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] tick_src,
    input  logic               ctrl_we,
    input  logic               ival_we,
    input  logic               cnt_we,
    input  logic [DATA_W-1:0]  wdata,
    output tmr_ctrl_t          ctrl_q,
    output logic [DATA_W-1:0]  ival_q,
    output logic [DATA_W-1:0]  cnt_q,
    output logic               expire
);
    logic gated_tick;
    logic step;
    logic at_one;

    assign gated_tick = ctrl_q.run && tick_src[ctrl_q.src];
    assign at_one     = (cnt_q == DATA_W'(1));
    assign expire     = step && at_one && !cnt_we;

    tmr_div div_i (
        .clk     (clk),
        .rst     (rst),
        .restart (ctrl_we || !ctrl_q.run),
        .tick    (gated_tick),
        .limit   (ctrl_q.div),
        .pulse   (step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);
        end else if (expire && ctrl_q.oneshot) begin
            ctrl_q.run <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ival_q <= '0;
        end else if (ival_we) begin
            ival_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_we) begin
            cnt_q <= wdata;
        end else if (step && cnt_q != '0) begin
            if (!at_one) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (!ctrl_q.oneshot && ctrl_q.reload) begin
                cnt_q <= ival_q;
            end else begin
                cnt_q <= '0;
            end
        end
    end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_bank_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] tick_src,
    output logic               irq
);
    logic [NUM_CH-1:0] en_q;
    logic [NUM_CH-1:0] pnd_q;
    logic              en_we;
    logic              pnd_we;

    tmr_ctrl_t               ctrl_all [NUM_CH];
    logic [NUM_CH-1:0][DATA_W-1:0] ival_all;
    logic [NUM_CH-1:0][DATA_W-1:0] cnt_all;
    logic [NUM_CH-1:0] ctrl_we_v;
    logic [NUM_CH-1:0] ival_we_v;
    logic [NUM_CH-1:0] cnt_we_v;
    logic [NUM_CH-1:0] expire_v;
    logic [NUM_CH-1:0] run_v;
    logic [NUM_CH-1:0] oneshot_v;

    assign en_we  = bus_wr && (bus_addr == OFS_EN);
    assign pnd_we = bus_wr && (bus_addr == OFS_PND);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign ctrl_we_v[g] = bus_wr && chan_hit(bus_addr, g, SUB_CTRL);
        assign ival_we_v[g] = bus_wr && chan_hit(bus_addr, g, SUB_IVAL);
        assign cnt_we_v[g]  = bus_wr && chan_hit(bus_addr, g, SUB_CNT);
        assign run_v[g]     = ctrl_all[g].run;
        assign oneshot_v[g] = ctrl_all[g].oneshot;

        tmr_chan chan_i (
            .clk      (clk),
            .rst      (rst),
            .tick_src (tick_src),
            .ctrl_we  (ctrl_we_v[g]),
            .ival_we  (ival_we_v[g]),
            .cnt_we   (cnt_we_v[g]),
            .wdata    (bus_wdata),
            .ctrl_q   (ctrl_all[g]),
            .ival_q   (ival_all[g]),
            .cnt_q    (cnt_all[g]),
            .expire   (expire_v[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            pnd_q <= '0;
        end else begin
            if (en_we) begin
                en_q <= bus_wdata[NUM_CH-1:0];
            end
            pnd_q <= (pnd_q & ~(pnd_we ? bus_wdata[NUM_CH-1:0] : '0)) | expire_v;
        end
    end

    assign irq = |(pnd_q & en_q);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_EN) begin
            bus_rdata[NUM_CH-1:0] = en_q;
        end else if (bus_addr == OFS_PND) begin
            bus_rdata[NUM_CH-1:0] = pnd_q;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (chan_hit(bus_addr, i, SUB_CTRL)) bus_rdata = DATA_W'(ctrl_all[i]);
            if (chan_hit(bus_addr, i, SUB_IVAL)) bus_rdata = ival_all[i];
            if (chan_hit(bus_addr, i, SUB_CNT))  bus_rdata = cnt_all[i];
        end
    end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
    import tmr_bank_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          pnd_we,
    input logic [DATA_W-1:0]             wdata,
    input logic [NUM_CH-1:0]             pnd_q,
    input logic [NUM_CH-1:0]             run_v,
    input logic [NUM_CH-1:0]             oneshot_v,
    input logic [NUM_CH-1:0]             ctrl_we_v,
    input logic [NUM_CH-1:0]             cnt_we_v,
    input logic [NUM_CH-1:0]             expire_v,
    input logic [NUM_CH-1:0][DATA_W-1:0] cnt_all
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R5
        frozen_cnt_chk: assert property (@(posedge clk) disable iff (rst)
            (!run_v[g] && !cnt_we_v[g]) |=> (cnt_all[g] == $past(cnt_all[g])));

        // R7
        oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
            (expire_v[g] && oneshot_v[g] && !ctrl_we_v[g]) |=> (!run_v[g] && cnt_all[g] == '0));

        // R9
        pnd_set_chk: assert property (@(posedge clk) disable iff (rst)
            expire_v[g] |=> pnd_q[g]);

        // R9
        pnd_clr_chk: assert property (@(posedge clk) disable iff (rst)
            (pnd_we && wdata[g] && !expire_v[g]) |=> !pnd_q[g]);

        // R11
        cnt_write_chk: assert property (@(posedge clk) disable iff (rst)
            cnt_we_v[g] |=> (cnt_all[g] == $past(wdata)));
    end
endmodule

bind tmr_bank tmr_bank_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .pnd_we    (pnd_we),
    .wdata     (bus_wdata),
    .pnd_q     (pnd_q),
    .run_v     (run_v),
    .oneshot_v (oneshot_v),
    .ctrl_we_v (ctrl_we_v),
    .cnt_we_v  (cnt_we_v),
    .expire_v  (expire_v),
    .cnt_all   (cnt_all)
);

// File: tb/tmr_bank_tb_top.sv
module tmr_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 6;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [3:0]  tick_src;
    logic        irq;

    int vectors = 0;
    int errors  = 0;

    // reference state
    logic [7:0]  m_ctrl [NCH];
    logic [31:0] m_ival [NCH];
    logic [31:0] m_cnt  [NCH];
    logic [2:0]  m_ph   [NCH];
    logic [NCH-1:0] m_en;
    logic [NCH-1:0] m_pnd;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_bank #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_src(tick_src), .irq(irq)
    );

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (a == 8'h00) return 32'(m_en);
        if (a == 8'h04) return 32'(m_pnd);
        for (int i = 0; i < NCH; i++) begin
            if (a == 8'(8'h10 + 16*i)) return 32'(m_ctrl[i]);
            if (a == 8'(8'h14 + 16*i)) return m_ival[i];
            if (a == 8'(8'h18 + 16*i)) return m_cnt[i];
        end
        return 32'h0;
    endfunction

    function automatic logic m_irq();
        return |(m_pnd & m_en);
    endfunction

    task automatic m_reset();
        for (int i = 0; i < NCH; i++) begin
            m_ctrl[i] = '0; m_ival[i] = '0; m_cnt[i] = '0; m_ph[i] = '0;
        end
        m_en = '0; m_pnd = '0;
    endtask

    task automatic m_step(input logic [7:0] a, input logic w, input logic [31:0] d,
                          input logic [3:0] t);
        logic [NCH-1:0] exp_v = '0;
        for (int i = 0; i < NCH; i++) begin
            logic [7:0] c = m_ctrl[i];
            logic cw = w && (a == 8'(8'h10 + 16*i));
            logic iw = w && (a == 8'(8'h14 + 16*i));
            logic nw = w && (a == 8'(8'h18 + 16*i));
            logic tk = c[0] && t[c[3:2]];
            logic pl = tk && (m_ph[i] >= c[6:4]);
            exp_v[i] = pl && (m_cnt[i] == 32'd1) && !nw;
            if (cw || !c[0]) m_ph[i] = '0;
            else if (tk) m_ph[i] = pl ? 3'd0 : m_ph[i] + 3'd1;
            if (nw) m_cnt[i] = d;
            else if (pl && m_cnt[i] != 0) begin
                if (m_cnt[i] != 1) m_cnt[i] = m_cnt[i] - 1;
                else m_cnt[i] = (!c[7] && c[1]) ? m_ival[i] : 32'd0;
            end
            if (iw) m_ival[i] = d;
            if (cw) m_ctrl[i] = d[7:0];
            else if (exp_v[i] && c[7]) m_ctrl[i][0] = 1'b0;
        end
        m_pnd = (m_pnd & ~((w && a == 8'h04) ? d[NCH-1:0] : '0)) | exp_v;
        if (w && a == 8'h00) m_en = d[NCH-1:0];
    endtask

    // one bus cycle: drive at negedge, step model at posedge, compare at next negedge
    task automatic cyc(input logic [7:0] a, input logic w, input logic [31:0] d,
                       input logic [3:0] t);
        bus_addr = a; bus_wr = w; bus_wdata = d; tick_src = t;
        @(posedge clk);
        m_step(a, w, d, t);
        @(negedge clk);
        vectors++;
        if (bus_rdata !== m_read(a)) begin
            errors++;
            $display("FAIL R2 read @%02h: got %08h expected %08h", a, bus_rdata, m_read(a));
        end
        vectors++;
        if (irq !== m_irq()) begin
            errors++;
            $display("FAIL R10 irq: got %0b expected %0b", irq, m_irq());
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        cyc(a, 1'b0, 32'h0, 4'h0);
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(a, 1'b1, d, 4'h0);
    endtask

    task automatic run_ticks(input int n, input logic [3:0] t);
        for (int k = 0; k < n; k++) cyc(8'h00, 1'b0, 32'h0, t);
    endtask

    initial begin
        int cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                errors++;
                $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; tick_src = '0;
        rst = 1'b1;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk("R1 en", 8'h00, 32'h0);
        rd_chk("R1 pending", 8'h04, 32'h0);
        rd_chk("R1 ctrl0", 8'h10, 32'h0);
        rd_chk("R1 cnt0", 8'h18, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);

        // R2 readback and unmapped offsets
        wr(8'h14, 32'hDEADBEEF);
        rd_chk("R2 interval", 8'h14, 32'hDEADBEEF);
        wr(8'h20, 32'h12345678);
        rd_chk("R2 ctrl upper zero", 8'h20, 32'h00000078);
        wr(8'h20, 32'h0);
        wr(8'h0C, 32'hFFFFFFFF);
        wr(8'h70, 32'hFFFFFFFF);
        wr(8'h1C, 32'hFFFFFFFF);
        rd_chk("R2 unmapped 0C", 8'h0C, 32'h0);
        rd_chk("R2 unmapped 08", 8'h08, 32'h0);
        rd_chk("R2 unmapped 1C", 8'h1C, 32'h0);
        rd_chk("R2 unmapped 70", 8'h70, 32'h0);
        rd_chk("R2 en untouched", 8'h00, 32'h0);

        // R4 source select on channel 2 (src field 2, run)
        wr(8'h38, 32'h55);
        rd_chk("R11 cnt write", 8'h38, 32'h55);
        wr(8'h30, 32'h09);
        run_ticks(5, 4'b1011);
        rd_chk("R4 other sources ignored", 8'h38, 32'h55);
        run_ticks(5, 4'b0100);
        rd_chk("R4 selected source counts", 8'h38, 32'h50);

        // R5 stopped channel holds
        wr(8'h30, 32'h08);
        run_ticks(5, 4'hF);
        rd_chk("R5 frozen", 8'h38, 32'h50);

        // R3 divider 3 => divide by 4
        wr(8'h30, 32'h39);
        run_ticks(12, 4'b0100);
        rd_chk("R3 divide by four", 8'h38, 32'h4D);
        wr(8'h30, 32'h0);

        // R6 reload on channel 3, masked pending
        wr(8'h44, 32'h3);
        wr(8'h48, 32'h2);
        wr(8'h40, 32'h03);
        run_ticks(2, 4'b0001);
        rd_chk("R6 reloaded", 8'h48, 32'h3);
        rd_chk("R9 pending while masked", 8'h04, 32'h8);
        chk("R10 irq masked", 32'(irq), 32'h0);
        wr(8'h00, 32'h8);
        chk("R10 irq enabled", 32'(irq), 32'h1);
        wr(8'h04, 32'h8);
        rd_chk("R9 cleared by one", 8'h04, 32'h0);
        chk("R10 irq after clear", 32'(irq), 32'h0);
        wr(8'h40, 32'h0);

        // R7 single-shot beats reload on channel 4
        wr(8'h54, 32'h9);
        wr(8'h58, 32'h2);
        wr(8'h50, 32'h83);
        run_ticks(2, 4'b0001);
        rd_chk("R7 count zero", 8'h58, 32'h0);
        rd_chk("R7 run cleared", 8'h50, 32'h82);
        run_ticks(4, 4'hF);
        rd_chk("R7 stays zero", 8'h58, 32'h0);

        // R8 continuous without reload on channel 5
        wr(8'h04, 32'h3F);
        wr(8'h68, 32'h1);
        wr(8'h60, 32'h01);
        run_ticks(1, 4'b0001);
        rd_chk("R8 count zero", 8'h68, 32'h0);
        rd_chk("R8 run kept", 8'h60, 32'h01);
        rd_chk("R8 pending set", 8'h04, 32'h20);
        wr(8'h04, 32'h20);
        run_ticks(4, 4'b0001);
        rd_chk("R8 no further expiry", 8'h04, 32'h0);
        wr(8'h60, 32'h0);

        // R11 write wins over a tick on a running channel
        wr(8'h18, 32'h5);
        wr(8'h10, 32'h01);
        cyc(8'h18, 1'b1, 32'h20, 4'hF);
        chk("R11 write beats tick", bus_rdata, 32'h20);
        wr(8'h10, 32'h0);

        // constrained random mix, compared against the reference every cycle
        for (int n = 0; n < 4000; n++) begin
            int unsigned r   = $urandom % 12;
            int unsigned ch  = $urandom % 7;
            logic [7:0]  a;
            logic [31:0] d;
            case (r)
                0:       a = 8'h00;
                1:       a = 8'h04;
                2:       a = 8'h08;
                default: a = 8'(8'h10 + 16*ch + 4*($urandom % 4));
            endcase
            if (a[3:0] == 4'h0 && a >= 8'h10) d = 32'($urandom % 256);
            else if (a < 8'h10)               d = $urandom;
            else                               d = 32'($urandom % 12);
            cyc(a, ($urandom % 3) == 0, d, 4'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule